// File: doc/BRIEF.md
# Code/Data Memory Strobe Decoder

This block sits between an 8051-class core and its memories. Each cycle it looks at the address bus, the program-fetch strobe, the data read and write strobes and the code-placement mode input. It then decides whether the access lands in on-chip memory or on the external 64 KB bus. Two regions are on-chip: a 16 KB RAM at the bottom of the address space and a 512-byte scratch-pad at 0xE000–0xE1FF. An access that falls inside either region raises the internal select and the internal read or write enable, and every external strobe stays inactive. An external memory can therefore be wired to the full 64 KB without an address decoder of its own.

On-chip RAM has a single read port for code and data. A fetch and a data read both drive the same internal read enable. When the mode input is high, program fetches to the low 16 KB go to the external bus, and the on-chip low RAM is reached only by data accesses. A fetch and a data write that both land on-chip in the same cycle are reported on a conflict output, and the write is dropped. All outputs are registered, with a synchronous active-high reset.

Top module: `memstrobe_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs go to idle on that edge: `iram_sel`=0, `conflict`=0, and every active-low strobe output is 1.
- R2: Outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge and holds between edges.
- R3: A data read or write (`rd_n`/`wr_n` low) to 0x0000–0x3FFF goes to on-chip RAM for either value of `ext_code`, and `xmem_rd_n`/`xmem_wr_n` stay high.
- R4: With `ext_code`=0, a fetch (`fetch_n` low) to 0x0000–0x3FFF drives `iram_rd_n` low and leaves `xmem_fetch_n` high.
- R5: With `ext_code`=1, a fetch to 0x0000–0x3FFF drives `xmem_fetch_n` low and does not read on-chip RAM.
- R6: Fetches, reads and writes to the scratch-pad 0xE000–0xE1FF go on-chip for either `ext_code` value, and all three external strobes stay high.
- R7: For an address outside both on-chip regions, each active input strobe appears on its external output (`fetch_n`→`xmem_fetch_n`, `rd_n`→`xmem_rd_n`, `wr_n`→`xmem_wr_n`), and `iram_sel` is 0.
- R8: An on-chip fetch and an on-chip data read both drive the single `iram_rd_n`, alone or together.
- R9: When an on-chip fetch and an on-chip write occur in the same cycle, `conflict` goes to 1 and `iram_wr_n` stays high.
- R10: `iram_sel` is 1 exactly when `iram_rd_n` or `iram_wr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Byte address of the access |
| fetch_n | input | 1 | Program-fetch strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| ext_code | input | 1 | 1 = low 16 KB of code space is off-chip |
| iram_sel | output | 1 | On-chip memory selected |
| iram_rd_n | output | 1 | On-chip read enable (fetch or data), active low |
| iram_wr_n | output | 1 | On-chip write enable, active low |
| xmem_rd_n | output | 1 | External data read strobe, active low |
| xmem_wr_n | output | 1 | External data write strobe, active low |
| xmem_fetch_n | output | 1 | External program-fetch strobe, active low |
| conflict | output | 1 | On-chip fetch and write in the same cycle |

## Verification
The bench goes to the region edges: 0x3FFF against 0x4000, and 0xDFFF, 0xE000, 0xE1FF and 0xE200. A decoder with an off-by-one compare would let an external strobe through inside a region, or would claim a byte that belongs to the external bus. Low-region fetches are run in both code modes, because a design that ignored the mode would keep reading on-chip code when it should fetch externally. Fetch-plus-write pairs are tried in three places: both on-chip, one off-chip, and both off-chip. These show whether a design flags a conflict only when both accesses are on-chip, and whether it really blocks the write. A latency check and a mid-traffic reset catch outputs that are combinational or that leave a strobe asserted through reset.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  // One registered decision per cycle; strobes are active low.
  typedef struct packed {
    logic sel;
    logic ird_n;
    logic iwr_n;
    logic xrd_n;
    logic xwr_n;
    logic xfetch_n;
    logic conflict;
  } mdec_out_t;

  localparam mdec_out_t MDEC_IDLE = '{
    sel: 1'b0, ird_n: 1'b1, iwr_n: 1'b1,
    xrd_n: 1'b1, xwr_n: 1'b1, xfetch_n: 1'b1, conflict: 1'b0
  };

endpackage

// File: rtl/mdec_region.sv
module mdec_region #(
  parameter int ADDR_W     = 16,
  parameter int IRAM_BYTES = 16384,
  parameter int SCR_BASE   = 'hE000,
  parameter int SCR_BYTES  = 512
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext_code,
  output logic              code_int,
  output logic              data_int
);

  localparam logic [ADDR_W:0] LOW_LIMIT = (ADDR_W+1)'(IRAM_BYTES);
  localparam bit SCR_POW2    = (SCR_BYTES & (SCR_BYTES - 1)) == 0;
  localparam bit SCR_ALIGNED = (SCR_BASE % SCR_BYTES) == 0;

  logic in_low;
  logic in_scr;

  assign in_low = {1'b0, addr} < LOW_LIMIT;

  // Aligned power-of-two pad: compare the upper address bits only.
  generate
    if (SCR_POW2 && SCR_ALIGNED) begin : g_scr_mask
      localparam int SCR_AW = $clog2(SCR_BYTES);
      localparam logic [ADDR_W-1:0] SCR_B = ADDR_W'(SCR_BASE);
      assign in_scr = addr[ADDR_W-1:SCR_AW] == SCR_B[ADDR_W-1:SCR_AW];
    end else begin : g_scr_range
      localparam logic [ADDR_W:0] SCR_LO = (ADDR_W+1)'(SCR_BASE);
      localparam logic [ADDR_W:0] SCR_HI = (ADDR_W+1)'(SCR_BASE + SCR_BYTES);
      assign in_scr = ({1'b0, addr} >= SCR_LO) && ({1'b0, addr} < SCR_HI);
    end
  endgenerate

  // Data space: both regions are always on-chip.
  assign data_int = in_low || in_scr;
  // Code space: the low RAM leaves the chip in external-code mode.
  assign code_int = (in_low && !ext_code) || in_scr;

endmodule

// File: rtl/mdec_route.sv
module mdec_route
  import mdec_pkg::*;
(
  input  logic      fetch_n,
  input  logic      rd_n,
  input  logic      wr_n,
  input  logic      code_int,
  input  logic      data_int,
  output mdec_out_t nxt
);

  logic want_f, want_r, want_w;
  logic on_f, on_r, on_w, clash;

  always_comb begin
    want_f = !fetch_n;
    want_r = !rd_n;
    want_w = !wr_n;

    on_f  = want_f && code_int;
    on_r  = want_r && data_int;
    on_w  = want_w && data_int;
    clash = on_f && on_w;

    nxt.ird_n    = !(on_f || on_r);
    nxt.iwr_n    = !(on_w && !clash);
    nxt.sel      = on_f || on_r || (on_w && !clash);
    nxt.conflict = clash;
    nxt.xfetch_n = !(want_f && !code_int);
    nxt.xrd_n    = !(want_r && !data_int);
    nxt.xwr_n    = !(want_w && !data_int);
  end

endmodule

// File: rtl/mdec_outreg.sv
module mdec_outreg
  import mdec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  mdec_out_t d,
  output mdec_out_t q
);

  always_ff @(posedge clk) begin
    if (rst) q <= MDEC_IDLE;
    else     q <= d;
  end

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    q.conflict |-> q.iwr_n); // R9

endmodule

// File: rtl/memstrobe_decoder.sv
module memstrobe_decoder
  import mdec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int IRAM_BYTES = 16384,
  parameter int SCR_BASE   = 'hE000,
  parameter int SCR_BYTES  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetch_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ext_code,
  output logic              iram_sel,
  output logic              iram_rd_n,
  output logic              iram_wr_n,
  output logic              xmem_rd_n,
  output logic              xmem_wr_n,
  output logic              xmem_fetch_n,
  output logic              conflict
);

  localparam logic [ADDR_W:0] LOW_LIMIT = (ADDR_W+1)'(IRAM_BYTES);
  localparam logic [ADDR_W:0] SCR_LO    = (ADDR_W+1)'(SCR_BASE);
  localparam logic [ADDR_W:0] SCR_HI    = (ADDR_W+1)'(SCR_BASE + SCR_BYTES);

  logic      code_int, data_int;
  mdec_out_t nxt, cur;

  mdec_region #(
    .ADDR_W(ADDR_W), .IRAM_BYTES(IRAM_BYTES),
    .SCR_BASE(SCR_BASE), .SCR_BYTES(SCR_BYTES)
  ) region_i (
    .addr(addr), .ext_code(ext_code),
    .code_int(code_int), .data_int(data_int)
  );

  mdec_route route_i (
    .fetch_n(fetch_n), .rd_n(rd_n), .wr_n(wr_n),
    .code_int(code_int), .data_int(data_int), .nxt(nxt)
  );

  mdec_outreg outreg_i (.clk(clk), .rst(rst), .d(nxt), .q(cur));

  assign iram_sel     = cur.sel;
  assign iram_rd_n    = cur.ird_n;
  assign iram_wr_n    = cur.iwr_n;
  assign xmem_rd_n    = cur.xrd_n;
  assign xmem_wr_n    = cur.xwr_n;
  assign xmem_fetch_n = cur.xfetch_n;
  assign conflict     = cur.conflict;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!iram_sel && iram_rd_n && iram_wr_n && xmem_rd_n &&
             xmem_wr_n && xmem_fetch_n && !conflict)); // R1

  AST_NO_EXT_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
    (!xmem_rd_n || !xmem_wr_n) |-> ({1'b0, $past(addr)} >= LOW_LIMIT)); // R3

  AST_EXT_FETCH_MODE: assert property (@(posedge clk) disable iff (rst)
    (!xmem_fetch_n && ({1'b0, $past(addr)} < LOW_LIMIT)) |-> $past(ext_code)); // R5

  AST_NO_EXT_IN_SCR: assert property (@(posedge clk) disable iff (rst)
    (!xmem_rd_n || !xmem_wr_n || !xmem_fetch_n) |->
      !(({1'b0, $past(addr)} >= SCR_LO) && ({1'b0, $past(addr)} < SCR_HI))); // R6

  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
    iram_sel == (!iram_rd_n || !iram_wr_n)); // R10

  AST_EXT_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!xmem_rd_n |-> !$past(rd_n)) and (!xmem_wr_n |-> !$past(wr_n))); // R7

endmodule

// File: tb/memstrobe_decoder_tb.sv
module memstrobe_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        fetch_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ext_code = 1'b0;
  logic        iram_sel, iram_rd_n, iram_wr_n, xmem_rd_n, xmem_wr_n;
  logic        xmem_fetch_n, conflict;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  memstrobe_decoder dut_i (
    .clk(clk), .rst(rst), .addr(addr), .fetch_n(fetch_n), .rd_n(rd_n),
    .wr_n(wr_n), .ext_code(ext_code), .iram_sel(iram_sel),
    .iram_rd_n(iram_rd_n), .iram_wr_n(iram_wr_n), .xmem_rd_n(xmem_rd_n),
    .xmem_wr_n(xmem_wr_n), .xmem_fetch_n(xmem_fetch_n), .conflict(conflict)
  );

  // Expected word: {sel, iram_rd_n, iram_wr_n, xmem_rd_n, xmem_wr_n, xmem_fetch_n, conflict}
  localparam logic [6:0] IDLE = 7'b0111110;
  // Row: {req, addr, {fetch_n, rd_n, wr_n, ext_code}, expected}
  localparam int NV = 21;
  localparam logic [30:0] VEC [NV] = '{
    {4'd3,  16'h0000, 4'b1010, 7'b1011110}, // R3 low data read
    {4'd3,  16'h3FFF, 4'b1100, 7'b1101110}, // R3 top of low RAM write
    {4'd7,  16'h4000, 4'b1010, 7'b0110110}, // R7 first external byte read
    {4'd7,  16'h4000, 4'b1100, 7'b0111010}, // R7 external write
    {4'd4,  16'h1234, 4'b0110, 7'b1011110}, // R4 internal code fetch
    {4'd5,  16'h1234, 4'b0111, 7'b0111100}, // R5 external code fetch
    {4'd3,  16'h1234, 4'b1011, 7'b1011110}, // R3 data read, ext_code=1
    {4'd3,  16'h1234, 4'b1101, 7'b1101110}, // R3 data write, ext_code=1
    {4'd6,  16'hE000, 4'b1010, 7'b1011110}, // R6 pad base read
    {4'd6,  16'hE1FF, 4'b1101, 7'b1101110}, // R6 pad top write
    {4'd7,  16'hE200, 4'b1010, 7'b0110110}, // R7 just above pad
    {4'd7,  16'hDFFF, 4'b1100, 7'b0111010}, // R7 just below pad
    {4'd6,  16'hE100, 4'b0111, 7'b1011110}, // R6 pad fetch, ext_code=1
    {4'd7,  16'h8000, 4'b0110, 7'b0111100}, // R7 external fetch
    {4'd9,  16'h0100, 4'b0100, 7'b1011111}, // R9 on-chip fetch+write
    {4'd5,  16'h0100, 4'b0101, 7'b1101100}, // R5 fetch off, write on: no clash
    {4'd7,  16'h8000, 4'b0100, 7'b0111000}, // R7 both external
    {4'd10, 16'h0000, 4'b1110, 7'b0111110}, // R10 idle, no select
    {4'd8,  16'h0000, 4'b0010, 7'b1011110}, // R8 fetch and read merged
    {4'd7,  16'hFFFF, 4'b1011, 7'b0110110}, // R7 top of space
    {4'd9,  16'hE000, 4'b0101, 7'b1011111}  // R9 pad fetch+write clash
  };

  function automatic logic [6:0] outs();
    return {iram_sel, iram_rd_n, iram_wr_n, xmem_rd_n, xmem_wr_n, xmem_fetch_n, conflict};
  endfunction

  task automatic check(input int req, input logic [6:0] exp, input string what);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, outs(), exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [3:0] s);
    addr = a;
    {fetch_n, rd_n, wr_n, ext_code} = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, IDLE, "idle during reset"); // R1
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][26:11], VEC[i][10:7]);
      @(negedge clk);
      check(int'(VEC[i][30:27]), VEC[i][6:0], $sformatf("vector %0d", i));
    end

    // R2: new inputs do not show before the next rising edge.
    @(negedge clk);
    drive(16'h8000, 4'b1010);
    @(negedge clk);
    check(7, 7'b0110110, "external read settled");
    drive(16'h0010, 4'b1100);
    #2;
    check(2, 7'b0110110, "output held before edge");
    @(negedge clk);
    check(2, 7'b1101110, "output after one edge");

    // R1: reset in mid-traffic forces idle while strobes stay asserted.
    drive(16'h9000, 4'b0100);
    rst = 1'b1;
    @(negedge clk);
    check(1, IDLE, "reset overrides active strobes");
    rst = 1'b0;
    @(negedge clk);
    check(7, 7'b0111000, "traffic resumes after reset");

    // R8: a data read alone on the low RAM also uses the shared read enable.
    drive(16'h2000, 4'b1010);
    @(negedge clk);
    check(8, 7'b1011110, "data read shares enable");

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    finish_run();
  end

endmodule